// File: doc/BRIEF.md
# DDR SDRAM Read Command Sequencer

This block sits between a single read requester and a DDR SDRAM device. Each request carries a flat address and a row-policy bit. The block decides whether the target row is already open, must be opened, or must first be closed and then reopened. It then issues the matching command sequence on the device command, bank and address pins, and raises a read-data-valid strobe once the CAS latency has passed.

One open-row register and one valid flag are kept per bank. The policy bit picks one of two behaviours for each request. When it is set, the READ carries the auto-precharge flag and the row closes after the burst. When it is clear, the row stays open so that a later request to the same row can skip the ACTIVE.

All timing is counted in clock cycles for a 133 MHz device clock: three cycles for tRCD and tRP, two cycles of CAS latency, and a fixed burst of four beats (two clock cycles). Reset release is treated as the DLL reset. No READ may go out until 200 cycles have elapsed after it.

Top module: `ddr_rd_seq`

## Requirements
- R1: The command pins {cs_n, ras_n, cas_n, we_n} use these codes: 0011 for ACTIVE, 0101 for READ, 0010 for PRECHARGE and 0111 for NOP. NOP is driven in reset, in every idle cycle, and in every cycle that carries no other command.
- R2: `req_ready` stays low for the first 200 rising edges after reset is released and rises after edge 200. No READ is issued before then.
- R3: `req_addr` is split as bank = bits [23:22], row = bits [21:9] and column = bits [8:0]. During ACTIVE, the bank is driven on `cmd_bank` and the 13-bit row on `cmd_addr`.
- R4: During READ, the bank is on `cmd_bank` and column bits 0 to 8 are on `cmd_addr[8:0]`. `cmd_addr[10]` equals the request's auto-close bit, and every other address bit is 0.
- R5: A request to a bank with no open row gives ACTIVE in the cycle after acceptance and READ three cycles after the ACTIVE.
- R6: A request whose row matches the open row of its bank gives READ in the cycle after acceptance, with no ACTIVE and no PRECHARGE.
- R7: A request to a bank whose open row differs gives PRECHARGE in the cycle after acceptance. That PRECHARGE carries the bank and has `cmd_addr[10]` low. ACTIVE follows three cycles after it, and READ three cycles after the ACTIVE.
- R8: `rd_valid` is high for exactly two cycles, starting two cycles after the READ.
- R9: `req_ready` is low from acceptance and rises four cycles after the READ when the row is left open, or seven cycles after the READ when auto-close is used.
- R10: After a READ with auto-close, the next request to that bank follows the empty-bank path (R5), even when it targets the same row.
- R11: Open rows are tracked per bank. Opening or closing a row in one bank does not change the hit or miss outcome for another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release marks the DLL reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 24 | Flat address {bank, row, column} |
| req_close | input | 1 | 1 = close the row after the burst (auto-precharge), 0 = leave it open |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_bank | output | 2 | Bank select pins |
| cmd_addr | output | 13 | Multiplexed row/column address pins |
| rd_valid | output | 1 | Read data beats valid (two beats per cycle) |

## Verification
The assertions assume that the requester never changes the address or policy bit in the cycle it is accepted. They also assume that the only source of bank activity is this block, so every gap between commands that an assertion measures comes from the block's own sequencing. The bench drives a request only at a falling edge on which it has seen `req_ready` high, and it holds the request for exactly one accepting edge. This respects both assumptions. The stimulus interleaves all four banks with rows that repeat and rows that change, so the hit, empty and miss paths each occur under both policy settings.

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq #(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4,
  parameter int INIT_WAIT = 200
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic                            req_close,
  output logic                            cmd_cs_n,
  output logic                            cmd_ras_n,
  output logic                            cmd_cas_n,
  output logic                            cmd_we_n,
  output logic [BANK_W-1:0]               cmd_bank,
  output logic [ROW_W-1:0]                cmd_addr,
  output logic                            rd_valid
);

  localparam int NB         = 1 << BANK_W;
  localparam int ADDR_W     = BANK_W + ROW_W + COL_W;
  localparam int BURST_CYC  = BURST_LEN / 2;
  localparam int PIPE       = CAS_LAT + BURST_CYC - 1;
  localparam int DRAIN_OPEN = CAS_LAT + BURST_CYC - 1;
  localparam int DRAIN_AP   = DRAIN_OPEN + T_RP;
  localparam int CNT_W      = $clog2(INIT_WAIT + DRAIN_AP + T_RCD + T_RP + 2) + 1;
  localparam int SINCE_W    = $clog2(T_RCD + T_RP + 2) + 1;

  localparam logic [CNT_W-1:0] C_INIT  = CNT_W'(INIT_WAIT - 1);
  localparam logic [CNT_W-1:0] C_RP    = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] C_RCD   = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] C_DOPEN = CNT_W'(DRAIN_OPEN);
  localparam logic [CNT_W-1:0] C_DAP   = CNT_W'(DRAIN_AP);
  localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);

  typedef enum logic [2:0] {
    S_INIT, S_IDLE, S_PRE, S_TRP, S_ACT, S_TRCD, S_RD, S_DRAIN
  } state_t;

  state_t                 st;
  logic [CNT_W-1:0]       cnt;
  logic [PIPE-1:0]        rd_pipe;
  logic [NB-1:0]          open_vld;
  logic [ROW_W-1:0]       open_row [NB];
  logic [BANK_W-1:0]      q_bank;
  logic [ROW_W-1:0]       q_row;
  logic [COL_W-1:0]       q_col;
  logic                   q_close;

  wire [BANK_W-1:0] a_bank = req_addr[ADDR_W-1 -: BANK_W];
  wire [ROW_W-1:0]  a_row  = req_addr[COL_W +: ROW_W];
  wire [COL_W-1:0]  a_col  = req_addr[COL_W-1:0];
  wire              acc    = req_valid && req_ready;

  function automatic logic [ROW_W-1:0] col_pins(input logic [COL_W-1:0] c, input logic ap);
    logic [ROW_W-1:0] a;
    a = '0;
    for (int i = 0; i < COL_W; i++) begin
      if (i < 10) a[i] = c[i];
      else        a[i+1] = c[i];
    end
    a[10] = ap;
    return a;
  endfunction

  assign req_ready = (st == S_IDLE);
  assign rd_valid  = |rd_pipe[PIPE-1:CAS_LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_INIT;
      cnt      <= '0;
      rd_pipe  <= '0;
      open_vld <= '0;
      for (int b = 0; b < NB; b++) open_row[b] <= '0;
      q_bank   <= '0;
      q_row    <= '0;
      q_col    <= '0;
      q_close  <= 1'b0;
    end else begin
      rd_pipe <= {rd_pipe[PIPE-2:0], st == S_RD};
      case (st)
        S_INIT: begin
          if (cnt == C_INIT) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + C_ONE;
          end
        end
        S_IDLE: begin
          if (acc) begin
            q_bank  <= a_bank;
            q_row   <= a_row;
            q_col   <= a_col;
            q_close <= req_close;
            if (!open_vld[a_bank])                st <= S_ACT;
            else if (open_row[a_bank] != a_row)   st <= S_PRE;
            else                                  st <= S_RD;
          end
        end
        S_PRE: begin
          open_vld[q_bank] <= 1'b0;
          cnt <= C_RP;
          st  <= S_TRP;
        end
        S_TRP: begin
          if (cnt == C_ONE) st <= S_ACT;
          else              cnt <= cnt - C_ONE;
        end
        S_ACT: begin
          open_vld[q_bank] <= 1'b1;
          open_row[q_bank] <= q_row;
          cnt <= C_RCD;
          st  <= S_TRCD;
        end
        S_TRCD: begin
          if (cnt == C_ONE) st <= S_RD;
          else              cnt <= cnt - C_ONE;
        end
        S_RD: begin
          if (q_close) open_vld[q_bank] <= 1'b0;
          cnt <= q_close ? C_DAP : C_DOPEN;
          st  <= S_DRAIN;
        end
        S_DRAIN: begin
          if (cnt == C_ONE) st <= S_IDLE;
          else              cnt <= cnt - C_ONE;
        end
        default: st <= S_INIT;
      endcase
    end
  end

  always_comb begin
    cmd_cs_n  = 1'b0;
    cmd_ras_n = 1'b1;
    cmd_cas_n = 1'b1;
    cmd_we_n  = 1'b1;
    cmd_bank  = '0;
    cmd_addr  = '0;
    case (st)
      S_PRE: begin
        cmd_ras_n = 1'b0;
        cmd_we_n  = 1'b0;
        cmd_bank  = q_bank;
      end
      S_ACT: begin
        cmd_ras_n = 1'b0;
        cmd_bank  = q_bank;
        cmd_addr  = q_row;
      end
      S_RD: begin
        cmd_cas_n = 1'b0;
        cmd_bank  = q_bank;
        cmd_addr  = col_pins(q_col, q_close);
      end
      default: ;
    endcase
  end

  wire is_nop = !cmd_cs_n &&  cmd_ras_n &&  cmd_cas_n &&  cmd_we_n;
  wire is_act = !cmd_cs_n && !cmd_ras_n &&  cmd_cas_n &&  cmd_we_n;
  wire is_rd  = !cmd_cs_n &&  cmd_ras_n && !cmd_cas_n &&  cmd_we_n;
  wire is_pre = !cmd_cs_n && !cmd_ras_n &&  cmd_cas_n && !cmd_we_n;

  logic [CNT_W-1:0]   age;
  logic [SINCE_W-1:0] since_act;
  logic [SINCE_W-1:0] since_pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age       <= '0;
      since_act <= '1;
      since_pre <= '1;
    end else begin
      if (age != '1) age <= age + C_ONE;
      if (is_act)              since_act <= SINCE_W'(1);
      else if (since_act != '1) since_act <= since_act + SINCE_W'(1);
      if (is_pre)              since_pre <= SINCE_W'(1);
      else if (since_pre != '1) since_pre <= since_pre + SINCE_W'(1);
    end
  end

  p_nop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> is_nop);

  p_init_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd || req_ready) |-> age >= CNT_W'(INIT_WAIT));

  p_trcd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |-> since_act >= SINCE_W'(T_RCD));

  p_trp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> since_pre >= SINCE_W'(T_RP));

  p_busy_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !req_ready);

  p_ap_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && cmd_addr[10]) |=> !open_vld[q_bank]);

endmodule

// File: tb/test_ddr_rd_seq.sv
`timescale 1ns/1ps
module test_ddr_rd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_close = 1'b0;
  logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        rd_valid;

  int tests = 0;
  int fails = 0;

  logic        m_open [4];
  logic [12:0] m_row  [4];
  logic        m_ap   [4];

  always #2 clk = ~clk;

  ddr_rd_seq i_ddr_rd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_close(req_close),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .rd_valid(rd_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cmd_code();
    return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
  endfunction

  task automatic do_req(input int b, input int row, input int col, input bit cls);
    int kind, prek, actk, rdk, rdyk;
    string tg;
    if (!m_open[b])               kind = 1;
    else if (m_row[b] != row[12:0]) kind = 2;
    else                          kind = 0;
    prek = -1; actk = -1;
    if (kind == 0) begin rdk = 1; tg = "R6 R11"; end
    else if (kind == 1) begin actk = 1; rdk = 4; tg = m_ap[b] ? "R5 R10" : "R5"; end
    else begin prek = 1; actk = 4; rdk = 7; tg = "R7 R11"; end
    rdyk = rdk + (cls ? 7 : 4);
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1;
    req_close = cls;
    req_addr  = {b[1:0], row[12:0], col[8:0]};
    for (int k = 1; k <= rdyk; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (k == prek) begin
        chk(cmd_code() == 4'b0010, {tg, " precharge code"}, cmd_code(), 4'b0010);
        chk(cmd_bank == b[1:0] && cmd_addr[10] == 1'b0, "R7 precharge bank/A10", cmd_bank, b);
      end else if (k == actk) begin
        chk(cmd_code() == 4'b0011, {tg, " active code"}, cmd_code(), 4'b0011);
        chk(cmd_bank == b[1:0], "R3 active bank", cmd_bank, b);
        chk(cmd_addr == row[12:0], "R3 active row", cmd_addr, row);
      end else if (k == rdk) begin
        chk(cmd_code() == 4'b0101, {tg, " read code"}, cmd_code(), 4'b0101);
        chk(cmd_bank == b[1:0], "R4 read bank", cmd_bank, b);
        chk(int'(cmd_addr) == (col | (int'(cls) << 10)), "R4 read column/A10", cmd_addr, col | (int'(cls) << 10));
      end else begin
        chk(cmd_code() == 4'b0111, "R1 nop between commands", cmd_code(), 4'b0111);
      end
      chk(rd_valid == (k == rdk + 2 || k == rdk + 3), "R8 read valid window", rd_valid, (k == rdk + 2 || k == rdk + 3));
      chk(req_ready == (k == rdyk), "R9 ready return", req_ready, (k == rdyk));
    end
    m_open[b] = !cls;
    m_row[b]  = row[12:0];
    m_ap[b]   = cls;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int edges;
    for (int b = 0; b < 4; b++) begin m_open[b] = 1'b0; m_row[b] = '0; m_ap[b] = 1'b0; end
    @(negedge clk);
    chk(cmd_code() == 4'b0111, "R1 reset nop", cmd_code(), 4'b0111);
    chk(req_ready == 1'b0, "R2 reset ready", req_ready, 0);
    chk(rd_valid == 1'b0, "R8 reset rd_valid", rd_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
    while (!req_ready && edges < 400) begin
      @(negedge clk);
      edges++;
      if (edges == 199) chk(req_ready == 1'b0, "R2 ready low at edge 199", req_ready, 0);
      chk(cmd_code() == 4'b0111, "R1 nop during init", cmd_code(), 4'b0111);
    end
    chk(edges == 200, "R2 init wait length", edges, 200);

    for (int s = 0; s < 12; s++) begin
      for (int b = 0; b < 4; b++) begin
        do_req(b, ((s * 5 + b) % 3) * 32'h0AB1 + b, (s * 37 + b * 11) % 512, (s % 4) == 3);
      end
    end
    do_req(2, 13'h1FFF, 9'h1FF, 1'b0);
    do_req(2, 13'h1FFF, 9'h000, 1'b1);
    do_req(2, 13'h1FFF, 9'h155, 1'b0);
    do_req(2, 13'h0000, 9'h0AA, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule